// File: doc/BRIEF.md
# Indirect PHY Register Access Bridge

This block gives a host access to the byte-wide internal registers of several serial PHYs through one 32-bit command word. The host writes a packed word. It holds a direction flag, a PHY number, a data byte and a 16-bit PHY-internal register address. The bridge then runs exactly one transaction on the chosen PHY's register port. Each port has an address, write data, a write enable, a read strobe and read data.

PHY register accesses need a long settle time. The bridge therefore holds a busy flag for a parameterised number of clock cycles after it accepts a command. A command presented while the bridge is busy is dropped. When a read finishes, the byte returned by the PHY is captured and shown in the byte field of the readback word. The readback word uses the same layout as the command word.

Top module: `phy_reg_bridge`

## Requirements
- R1: After reset, `busy` is 0, `host_rdata` is 0 and every PHY write enable, read strobe, address and write-data line is 0.
- R2: A command is accepted on a clock edge where `host_wr` is 1 and `busy` is 0. `busy` is 1 for exactly SETTLE_CYC cycles, starting the cycle after acceptance.
- R3: A write command (bit 31 = 1) pulses the selected PHY's write enable for exactly one cycle, the first busy cycle. During that cycle the PHY address carries bits 15:0 and the PHY write data carries bits 23:16.
- R4: A read command (bit 31 = 0) holds the selected PHY's read strobe high for the whole busy period. The PHY read data is captured at the clock edge that ends the busy period.
- R5: Bits 30:24 select the PHY: value 0 drives port 0 and value 1 drives port 1. No other port sees a strobe.
- R6: A select value of NUM_PHY or more still produces a full busy period, but it drives no strobe on any port, and the readback byte field is 0x00.
- R7: A command written while `busy` is 1 is ignored. It causes no strobe, and the readback word keeps the accepted command.
- R8: The readback word holds bit 31 = direction, bits 30:24 = select and bits 15:0 = address of the last accepted command. Bits 23:16 hold the write byte for a write. For a read they hold 0x00 until the read completes and the captured byte after that.
- R9: The address and write-data lines of a port are 0 whenever that port is not the selected, valid target of the command in progress.

Top module parameters: NUM_PHY (default 2) and SETTLE_CYC (default 42500, which is 850 µs at 50 MHz).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Host command write strobe |
| host_wdata | input | 32 | Command word |
| host_rdata | output | 32 | Readback word |
| busy | output | 1 | Transaction in progress |
| phy_addr | output | NUM_PHY*16 | Per-port register address, port 0 in the low slice |
| phy_wdata | output | NUM_PHY*8 | Per-port write byte |
| phy_we | output | NUM_PHY | Per-port write enable |
| phy_rd | output | NUM_PHY | Per-port read strobe |
| phy_rdata | input | NUM_PHY*8 | Per-port read byte |

## Verification
Assertions check these rules on every cycle:
- The write enable is never longer than one cycle.
- At most one port strobe is active at a time.
- All strobes are silent when the bridge is idle or the select is invalid.
- The settle counter stays in range.
- The read strobe ends together with busy.
- The readback word stays frozen while busy.

Only the bench scenarios can show the remaining behaviour. These include the captured read value, including a PHY value that changes mid-settle. They also cover writes landing on the right PHY and only that PHY, dropped commands leaving no trace, and a command accepted on the very cycle busy falls.

// File: rtl/phybr_pkg.sv
package phybr_pkg;
    localparam int REG_ADDR_W = 16;
    localparam int BYTE_W     = 8;
    localparam int SEL_W      = 7;
    localparam int CMD_W      = 1 + SEL_W + BYTE_W + REG_ADDR_W;

    // Field order is the host-visible word layout (bit 31 down to bit 0).
    typedef struct packed {
        logic                  is_write;
        logic [SEL_W-1:0]      sel;
        logic [BYTE_W-1:0]     byte_val;
        logic [REG_ADDR_W-1:0] addr;
    } cmd_t;

    typedef struct packed {
        cmd_t              cmd;
        logic [BYTE_W-1:0] rd_byte;
        logic              sel_ok;
    } bridge_state_t;
endpackage

// File: rtl/cmd_decode.sv
module cmd_decode
    import phybr_pkg::*;
#(
    parameter int NUM_PHY = 2
) (
    input  logic [CMD_W-1:0] word,
    output cmd_t             cmd,
    output logic             sel_ok
);
    always_comb begin
        cmd    = cmd_t'(word);
        sel_ok = (int'(cmd.sel) < NUM_PHY);
    end
endmodule

// File: rtl/settle_timer.sv
module settle_timer #(
    parameter int SETTLE_CYC = 42500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic active,
    output logic first,
    output logic last
);
    localparam int CNT_W = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(SETTLE_CYC - 1);

    typedef struct packed {
        logic             act;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (tmr_q.act) begin
            if (tmr_q.cnt == LAST_CNT) begin
                tmr_d.act = 1'b0;
                tmr_d.cnt = '0;
            end else begin
                tmr_d.cnt = tmr_q.cnt + 1'b1;
            end
        end else if (start) begin
            tmr_d.act = 1'b1;
            tmr_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign active = tmr_q.act;
    assign first  = tmr_q.act && (tmr_q.cnt == '0);
    assign last   = tmr_q.act && (tmr_q.cnt == LAST_CNT);

    // R2
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_q.act |-> (int'(tmr_q.cnt) < SETTLE_CYC));

    // R2
    idle_cnt_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tmr_q.act |-> (tmr_q.cnt == '0));
endmodule

// File: rtl/phy_port_fanout.sv
module phy_port_fanout
    import phybr_pkg::*;
#(
    parameter int NUM_PHY = 2,
    localparam int IDX_W = (NUM_PHY > 1) ? $clog2(NUM_PHY) : 1
) (
    input  logic                          en,
    input  logic [IDX_W-1:0]              sel_idx,
    input  logic                          is_write,
    input  logic                          first,
    input  logic [REG_ADDR_W-1:0]         addr,
    input  logic [BYTE_W-1:0]             wbyte,
    output logic [NUM_PHY*REG_ADDR_W-1:0] phy_addr,
    output logic [NUM_PHY*BYTE_W-1:0]     phy_wdata,
    output logic [NUM_PHY-1:0]            phy_we,
    output logic [NUM_PHY-1:0]            phy_rd,
    input  logic [NUM_PHY*BYTE_W-1:0]     phy_rdata,
    output logic [BYTE_W-1:0]             rbyte
);
    for (genvar g = 0; g < NUM_PHY; g++) begin : g_port
        logic hit;
        assign hit = en && (sel_idx == IDX_W'(g));
        assign phy_addr[g*REG_ADDR_W +: REG_ADDR_W] = hit ? addr  : '0;
        assign phy_wdata[g*BYTE_W +: BYTE_W]        = hit ? wbyte : '0;
        assign phy_we[g] = hit && is_write && first;
        assign phy_rd[g] = hit && !is_write;
    end

    always_comb begin
        rbyte = '0;
        for (int i = 0; i < NUM_PHY; i++) begin
            if (sel_idx == IDX_W'(i)) rbyte = phy_rdata[i*BYTE_W +: BYTE_W];
        end
    end
endmodule

// File: rtl/phy_reg_bridge.sv
module phy_reg_bridge
    import phybr_pkg::*;
#(
    parameter int NUM_PHY    = 2,
    parameter int SETTLE_CYC = 42500
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          host_wr,
    input  logic [31:0]                   host_wdata,
    output logic [31:0]                   host_rdata,
    output logic                          busy,
    output logic [NUM_PHY*REG_ADDR_W-1:0] phy_addr,
    output logic [NUM_PHY*BYTE_W-1:0]     phy_wdata,
    output logic [NUM_PHY-1:0]            phy_we,
    output logic [NUM_PHY-1:0]            phy_rd,
    input  logic [NUM_PHY*BYTE_W-1:0]     phy_rdata
);
    localparam int IDX_W = (NUM_PHY > 1) ? $clog2(NUM_PHY) : 1;

    bridge_state_t st_d, st_q;
    cmd_t          new_cmd;
    logic          new_ok;
    logic          t_active, t_first, t_last, accept;
    logic [BYTE_W-1:0] rbyte;
    logic [IDX_W-1:0]  sel_idx;

    cmd_decode #(.NUM_PHY(NUM_PHY)) u_dec (
        .word   (host_wdata),
        .cmd    (new_cmd),
        .sel_ok (new_ok)
    );

    assign accept = host_wr && !t_active;

    settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (accept),
        .active (t_active),
        .first  (t_first),
        .last   (t_last)
    );

    assign sel_idx = st_q.cmd.sel[IDX_W-1:0];

    phy_port_fanout #(.NUM_PHY(NUM_PHY)) u_fan (
        .en        (t_active && st_q.sel_ok),
        .sel_idx   (sel_idx),
        .is_write  (st_q.cmd.is_write),
        .first     (t_first),
        .addr      (st_q.cmd.addr),
        .wbyte     (st_q.cmd.byte_val),
        .phy_addr  (phy_addr),
        .phy_wdata (phy_wdata),
        .phy_we    (phy_we),
        .phy_rd    (phy_rd),
        .phy_rdata (phy_rdata),
        .rbyte     (rbyte)
    );

    always_comb begin
        st_d = st_q;
        if (accept) begin
            st_d.cmd     = new_cmd;
            st_d.sel_ok  = new_ok;
            st_d.rd_byte = '0;
        end else if (t_last && !st_q.cmd.is_write && st_q.sel_ok) begin
            st_d.rd_byte = rbyte;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy       = t_active;
    assign host_rdata = {st_q.cmd.is_write, st_q.cmd.sel,
                         st_q.cmd.is_write ? st_q.cmd.byte_val : st_q.rd_byte,
                         st_q.cmd.addr};

    // R3
    we_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|phy_we) |=> (phy_we == '0));

    // R5
    strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(phy_we | phy_rd));

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> ((phy_we | phy_rd) == '0));

    // R6
    bad_sel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !st_q.sel_ok) |-> ((phy_we | phy_rd) == '0));

    // R4
    rd_ends_with_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|$past(phy_rd)) && (phy_rd == '0)) |-> !busy);

    // R7
    readback_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(host_rdata));
endmodule

// File: tb/sim_phy_reg_bridge.sv
module sim_phy_reg_bridge;
    localparam int NP     = 2;
    localparam int SETTLE = 6;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        host_wr = 0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        busy;
    logic [NP*16-1:0] phy_addr;
    logic [NP*8-1:0]  phy_wdata;
    logic [NP-1:0]    phy_we, phy_rd;
    logic [NP*8-1:0]  phy_rdata;

    always #10 clk = ~clk;

    phy_reg_bridge #(.NUM_PHY(NP), .SETTLE_CYC(SETTLE)) u0 (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .busy(busy), .phy_addr(phy_addr),
        .phy_wdata(phy_wdata), .phy_we(phy_we), .phy_rd(phy_rd),
        .phy_rdata(phy_rdata)
    );

    int checks = 0, errors = 0, cycles = 0;
    bit finished = 0;

    function automatic logic [7:0] dflt(int p, int a);
        return 8'(a * 7 + p * 8'h5B + 3);
    endfunction

    // PHY register files seen by the DUT, and the model's own shadow copy
    logic [7:0] pm [NP][256];
    logic [7:0] rm [NP][256];
    initial
        for (int p = 0; p < NP; p++)
            for (int a = 0; a < 256; a++) begin
                pm[p][a] = dflt(p, a);
                rm[p][a] = dflt(p, a);
            end

    assign phy_rdata = {pm[1][phy_addr[23:16]], pm[0][phy_addr[7:0]]};

    always @(posedge clk)
        for (int p = 0; p < NP; p++)
            if (phy_we[p]) pm[p][phy_addr[p*16 +: 8]] <= phy_wdata[p*8 +: 8];

    // Reference model
    int         r_left = 0, r_sel = 0;
    bit         r_wr = 0;
    logic [7:0] r_byte = 0, r_rdb = 0;
    logic [15:0] r_addr = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            r_left = 0; r_sel = 0; r_wr = 0; r_byte = 0; r_rdb = 0; r_addr = 0;
        end else if (r_left > 0) begin
            if (r_left == 1 && !r_wr && r_sel < NP) r_rdb = rm[r_sel][r_addr[7:0]];
            r_left--;
        end else if (host_wr) begin
            r_wr   = host_wdata[31];
            r_sel  = int'(host_wdata[30:24]);
            r_byte = host_wdata[23:16];
            r_addr = host_wdata[15:0];
            r_rdb  = 0;
            r_left = SETTLE;
            if (r_wr && r_sel < NP) rm[r_sel][r_addr[7:0]] = r_byte;
        end
    end

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Per-cycle comparison away from the active edge
    always @(negedge clk) if (rst_n && !finished) begin
        logic eb;
        logic [NP-1:0] ewe, erd;
        logic [NP*16-1:0] ea;
        logic [NP*8-1:0] ed;
        eb = (r_left > 0);
        ewe = '0; erd = '0; ea = '0; ed = '0;
        for (int p = 0; p < NP; p++)
            if (eb && r_sel == p) begin
                ewe[p] = r_wr && (r_left == SETTLE);
                erd[p] = !r_wr;
                ea[p*16 +: 16] = r_addr;
                ed[p*8 +: 8]   = r_byte;
            end
        check("R2 busy", 64'(busy), 64'(eb));
        check("R3 write enable", 64'(phy_we), 64'(ewe));
        check("R4 read strobe", 64'(phy_rd), 64'(erd));
        check("R8 readback", 64'(host_rdata),
              64'({r_wr, 7'(r_sel), r_wr ? r_byte : r_rdb, r_addr}));
        check("R9 port address", 64'(phy_addr), 64'(ea));
        check("R9 port wdata", 64'(phy_wdata), 64'(ed));
    end

    task automatic send(bit wr, int sel, logic [7:0] b, logic [15:0] a);
        @(negedge clk);
        host_wr = 1;
        host_wdata = {wr, 7'(sel), b, a};
        @(negedge clk);
        host_wr = 0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !finished) begin
            finished = 1;
            errors++;
            $display("FAIL watchdog actual=%0d expected=<20000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 busy", 64'(busy), 0);
        check("R1 readback", 64'(host_rdata), 0);
        check("R1 strobes", 64'({phy_we, phy_rd}), 0);
        check("R1 lines", 64'({phy_addr, phy_wdata}), 0);
        rst_n = 1;
        repeat (2) @(negedge clk);

        // R3: write PHY0
        send(1, 0, 8'hC9, 16'h0065);
        wait_idle();
        check("R3 phy0 stored", 64'(pm[0][8'h65]), 64'h00C9);
        // R4: read back PHY0
        send(0, 0, 8'hEE, 16'h0065);
        wait_idle();
        check("R4 read byte", 64'(host_rdata[23:16]), 64'h00C9);

        // R5: write PHY1, PHY0 untouched
        send(1, 1, 8'hAA, 16'h8065);
        wait_idle();
        check("R5 phy1 stored", 64'(pm[1][8'h65]), 64'h00AA);
        check("R5 phy0 untouched", 64'(pm[0][8'h65]), 64'h00C9);
        send(0, 1, 8'h00, 16'h8065);
        wait_idle();
        check("R5 read phy1", 64'(host_rdata[23:16]), 64'h00AA);

        // R6: out-of-range select
        send(1, 3, 8'h77, 16'h0020);
        wait_idle();
        check("R6 no write phy0", 64'(pm[0][8'h20]), 64'(dflt(0, 32'h20)));
        check("R6 no write phy1", 64'(pm[1][8'h20]), 64'(dflt(1, 32'h20)));
        send(0, 127, 8'h55, 16'h0021);
        wait_idle();
        check("R6 read byte zero", 64'(host_rdata[23:16]), 0);

        // R7: command while busy is dropped
        send(1, 0, 8'h11, 16'h0010);
        @(negedge clk);
        host_wr = 1; host_wdata = {1'b1, 7'd1, 8'h22, 16'h0010};
        @(negedge clk);
        host_wr = 0;
        wait_idle();
        check("R7 readback kept", 64'(host_rdata), 64'h8011_0010);
        check("R7 phy1 untouched", 64'(pm[1][8'h10]), 64'(dflt(1, 32'h10)));

        // R4: value changing mid-settle is captured at the end
        send(0, 0, 8'h00, 16'h0030);
        @(negedge clk);
        pm[0][8'h30] = 8'h3D;
        rm[0][8'h30] = 8'h3D;
        wait_idle();
        check("R4 late capture", 64'(host_rdata[23:16]), 64'h003D);

        // R2: command held across the end of busy is taken right away
        @(negedge clk);
        host_wr = 1; host_wdata = {1'b0, 7'd1, 8'h00, 16'h0042};
        @(negedge clk);
        host_wdata = {1'b1, 7'd0, 8'h99, 16'h0043};
        while (busy) @(negedge clk);
        @(negedge clk);
        host_wr = 0;
        check("R2 back-to-back busy", 64'(busy), 1);
        wait_idle();
        check("R3 second write landed", 64'(pm[0][8'h43]), 64'h0099);

        repeat (3) @(negedge clk);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule